// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them with line 0 as the most urgent, and raises a single interrupt output toward a processor. The processor configures it and reads it back through a byte-wide port with one address bit, so there is an even port and an odd port. Chip-select, read and write strobes qualify each access. When the processor pulses the acknowledge input, the winning request moves into the in-service register. An 8-bit vector, built from a programmed base and the line number, then appears on the data output.

Software must set the block up with a fixed sequence. An even-port write with bit 4 set starts it, and the next three odd-port writes follow in order. After that, the odd port reaches the mask register. Even-port writes then serve as commands: they end service for one line or for the most urgent line, and they choose whether even-port reads return pending requests or in-service lines. The same core can sit as the master or as a slave of a two-level tree. A configuration input picks the role. A master hands its cascaded inputs to a slave by naming the line on a cascade bus. A slave answers an acknowledge only when its own ID appears on that bus.

Top module: `pic8_core`

## Requirements
- R1: After reset the mask register reads 0xFF on the odd port, int_o, cas_en_o and dout_o are 0, and the block is unconfigured.
- R2: An even-port write with bit 4 set restarts setup. It clears the mask, request and in-service registers, selects request read-back and clears auto-EOI. The next three odd-port writes load, in order, the vector base, the cascade word and the mode word. Until the third of these writes lands, int_o stays 0 and acknowledge pulses are ignored.
- R3: One cycle after an accepted acknowledge, dout_o holds the vector: bits 7:3 of the base with the served line number in bits 2:0.
- R4: After setup, odd-port writes load the mask and odd-port reads return it. A 1 bit blocks that line from int_o and from service, but its request bit is still recorded.
- R5: An even-port command with bit 4 = 0 and bit 3 = 1 sets read-back when bits 1:0 are 10 (request register, e.g. 0x0A) or 11 (in-service register, e.g. 0x0B). The choice holds until it is changed.
- R6: Command 0x60+n (bits 7:5 = 011) clears in-service bit n only. Command 0x20 (bits 7:5 = 001) clears the set in-service bit of highest priority.
- R7: Line 0 is the most urgent. int_o is 1 only when an unmasked pending request is strictly more urgent than every set in-service bit.
- R8: On an accepted acknowledge, the most urgent eligible request leaves the request register. In normal mode its in-service bit is set. When mode-word bit 1 is 1 (auto-EOI, e.g. 0x03), no in-service bit is set. In-service bits are set at no other time.
- R9: If no request is eligible at an acknowledge, dout_o gets base+7 and the in-service register is unchanged. This also applies when requests are pending but masked.
- R10: With level_i[n] = 0, a rising edge on ir_i[n] records a request, and the request drops if the line falls before service. A line held high after service is not requested again. With level_i[n] = 1, the request follows the line and returns one cycle after service if the line stays high.
- R11: On a master (slave_i = 0), serving a line whose cascade-word bit is set pulses cas_en_o for one cycle with cas_id_o = line number. The in-service bit is set and dout_o is left unchanged.
- R12: On a slave (slave_i = 1), an acknowledge is acted on only when cas_id_i equals cascade-word bits 2:0. Otherwise nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select for register access |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| a0_i | input | 1 | Port select: 0 even, 1 odd |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Registered read data or vector |
| ir_i | input | 8 | Interrupt request lines |
| level_i | input | 8 | Per-line level (1) or edge (0) capture |
| slave_i | input | 1 | Role: 1 slave, 0 master |
| inta_i | input | 1 | Acknowledge pulse, one cycle |
| cas_id_i | input | 3 | Cascade line number seen by a slave |
| int_o | output | 1 | Interrupt request to the processor |
| cas_en_o | output | 1 | Master is handing this acknowledge to a slave |
| cas_id_o | output | 3 | Line number of the cascaded input |

## Verification
A request line change reaches the request register at the first clock edge. int_o follows combinationally from the registers, so it is due one edge after ir_i moves. Register writes and acknowledges also take effect at the edge that captures them. dout_o and the cascade outputs are registered and are due at that same edge. The bench drives every stimulus at a falling edge, removes strobes at the next falling edge and samples there. Each check therefore lands exactly one rising edge after its stimulus. For level capture and re-request, where the result comes one edge later, the bench waits one more falling edge before sampling.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_BASE = 3'd1,
    ST_CASC = 3'd2,
    ST_MODE = 3'd3,
    ST_RUN  = 3'd4
  } cfg_st_e;

  localparam logic [2:0] OP_SEOI = 3'b011;
  localparam logic [2:0] OP_NEOI = 3'b001;
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
  import pic8_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             wr_i,
  input  logic             a0_i,
  input  logic [DW-1:0]    din_i,
  output logic             start_o,
  output logic             cmd_wr_o,
  output logic             ready_o,
  output logic [DW-1:0]    imr_o,
  output logic [DW-IW-1:0] base_o,
  output logic [DW-1:0]    casc_o,
  output logic             aeoi_o,
  output logic             rd_isr_o
);
  cfg_st_e st_q;
  logic    wr_even, wr_odd;

  assign wr_even  = cs_i && wr_i && !a0_i;
  assign wr_odd   = cs_i && wr_i && a0_i;
  assign start_o  = wr_even && din_i[4];
  assign ready_o  = (st_q == ST_RUN);
  // end-of-interrupt command group: bits 4:3 both clear
  assign cmd_wr_o = wr_even && ready_o && !din_i[4] && !din_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_OFF;
      imr_o    <= '1;
      base_o   <= '0;
      casc_o   <= '0;
      aeoi_o   <= 1'b0;
      rd_isr_o <= 1'b0;
    end else if (start_o) begin
      st_q     <= ST_BASE;
      imr_o    <= '0;
      aeoi_o   <= 1'b0;
      rd_isr_o <= 1'b0;
    end else if (wr_even) begin
      if (ready_o && din_i[3] && din_i[1]) rd_isr_o <= din_i[0];
    end else if (wr_odd) begin
      unique case (st_q)
        ST_BASE: begin base_o <= din_i[DW-1:IW]; st_q <= ST_CASC; end
        ST_CASC: begin casc_o <= din_i;          st_q <= ST_MODE; end
        ST_MODE: begin aeoi_o <= din_i[1];       st_q <= ST_RUN;  end
        ST_RUN:  imr_o <= din_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic8_req.sv
module pic8_req #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [N-1:0] ir_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] ir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ir_q <= '0;
    else         ir_q <= ir_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    logic nxt;
    always_comb begin
      if (clr_all_i || ack_clr_i[g]) nxt = 1'b0;
      else if (level_i[g])           nxt = ir_i[g];
      else                           nxt = ir_i[g] && (irr_o[g] || !ir_q[g]);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irr_o[g] <= 1'b0;
      else         irr_o[g] <= nxt;
    end
  end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  imr_i,
  input  logic [N-1:0]  isr_i,
  output logic [IW-1:0] req_idx_o,
  output logic          isr_hit_o,
  output logic [IW-1:0] isr_idx_o,
  output logic          int_req_o
);
  logic [N-1:0] pend;
  logic         req_hit;

  assign pend = irr_i & ~imr_i;

  always_comb begin
    req_hit   = 1'b0;
    req_idx_o = '0;
    isr_hit_o = 1'b0;
    isr_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i])  begin req_hit   = 1'b1; req_idx_o = IW'(i); end
      if (isr_i[i]) begin isr_hit_o = 1'b1; isr_idx_o = IW'(i); end
    end
    int_req_o = req_hit && (!isr_hit_o || (req_idx_o < isr_idx_o));
  end
endmodule

// File: rtl/pic8_core.sv
module pic8_core
  import pic8_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NUM_IR = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_i,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic                      a0_i,
  input  logic [DW-1:0]             din_i,
  output logic [DW-1:0]             dout_o,
  input  logic [NUM_IR-1:0]         ir_i,
  input  logic [NUM_IR-1:0]         level_i,
  input  logic                      slave_i,
  input  logic                      inta_i,
  input  logic [$clog2(NUM_IR)-1:0] cas_id_i,
  output logic                      int_o,
  output logic                      cas_en_o,
  output logic [$clog2(NUM_IR)-1:0] cas_id_o
);
  localparam int IW = $clog2(NUM_IR);

  logic              start, cmd_wr, ready, aeoi, rd_isr;
  logic [DW-1:0]     imr_q, casc;
  logic [DW-IW-1:0]  base;
  logic [NUM_IR-1:0] irr_q, isr_q, isr_d, set_vec, eoi_clr;
  logic [IW-1:0]     req_idx, isr_idx;
  logic              isr_hit, int_req;
  logic              ack_ok, take, to_slave;

  pic8_cfg #(.DW(DW), .IW(IW)) cfg_i (
    .clk_i, .rst_ni, .cs_i, .wr_i, .a0_i, .din_i,
    .start_o(start), .cmd_wr_o(cmd_wr), .ready_o(ready), .imr_o(imr_q),
    .base_o(base), .casc_o(casc), .aeoi_o(aeoi), .rd_isr_o(rd_isr)
  );

  pic8_req #(.N(NUM_IR)) req_i (
    .clk_i, .rst_ni, .clr_all_i(start), .ir_i, .level_i,
    .ack_clr_i(set_vec), .irr_o(irr_q)
  );

  pic8_prio #(.N(NUM_IR), .IW(IW)) prio_i (
    .irr_i(irr_q), .imr_i(imr_q[NUM_IR-1:0]), .isr_i(isr_q),
    .req_idx_o(req_idx), .isr_hit_o(isr_hit), .isr_idx_o(isr_idx),
    .int_req_o(int_req)
  );

  assign int_o    = ready && int_req;
  assign ack_ok   = ready && inta_i && (!slave_i || (cas_id_i == casc[IW-1:0]));
  assign take     = ack_ok && int_req;
  assign to_slave = take && !slave_i && casc[req_idx];

  always_comb begin
    for (int i = 0; i < NUM_IR; i++) begin
      set_vec[i] = take && (req_idx == IW'(i));
      eoi_clr[i] = cmd_wr &&
                   (((din_i[7:5] == OP_SEOI) && (din_i[IW-1:0] == IW'(i))) ||
                    ((din_i[7:5] == OP_NEOI) && isr_hit && (isr_idx == IW'(i))));
    end
    isr_d = (isr_q & ~eoi_clr) | (aeoi ? '0 : set_vec);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    isr_q <= '0;
    else if (start) isr_q <= '0;
    else            isr_q <= isr_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o   <= '0;
      cas_en_o <= 1'b0;
      cas_id_o <= '0;
    end else begin
      cas_en_o <= to_slave;
      cas_id_o <= to_slave ? req_idx : '0;
      if (ack_ok && !to_slave)
        dout_o <= {base, (take ? req_idx : {IW{1'b1}})};
      else if (cs_i && rd_i)
        dout_o <= a0_i ? imr_q : (rd_isr ? DW'(isr_q) : DW'(irr_q));
    end
  end
endmodule

// File: rtl/pic8_core_chk.sv
module pic8_core_chk #(
  parameter int NUM_IR = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              wr_i,
  input logic              inta_i,
  input logic              slave_i,
  input logic              int_o,
  input logic              cas_en_o,
  input logic              ready,
  input logic              aeoi,
  input logic [7:0]        imr_q,
  input logic [NUM_IR-1:0] irr_q,
  input logic [NUM_IR-1:0] isr_q
);
  AST_INT_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> !int_o); // R2
  AST_INT_HAS_UNMASKED_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr_q & ~imr_q[NUM_IR-1:0]) != '0)); // R7
  AST_ACK_SETS_AT_MOST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> ($countones(isr_q & ~$past(isr_q)) <= 1)); // R8
  AST_NO_SET_WITHOUT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_i |=> ((isr_q & ~$past(isr_q)) == '0)); // R8
  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aeoi && inta_i && !(cs_i && wr_i)) |=> $stable(isr_q)); // R8
  AST_MASKED_NOT_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inta_i |=> (((isr_q & ~$past(isr_q)) & $past(imr_q[NUM_IR-1:0])) == '0)); // R4
  AST_CAS_ONLY_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_en_o |-> $past(!slave_i)); // R11
endmodule

bind pic8_core pic8_core_chk #(.NUM_IR(NUM_IR)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .wr_i(wr_i), .inta_i(inta_i),
  .slave_i(slave_i), .int_o(int_o), .cas_en_o(cas_en_o), .ready(ready),
  .aeoi(aeoi), .imr_q(imr_q), .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/pic8_core_tb_top.sv
module pic8_core_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] OP_WE = 4'd0;
  localparam logic [3:0] OP_WO = 4'd1;
  localparam logic [3:0] OP_RE = 4'd2;
  localparam logic [3:0] OP_RO = 4'd3;
  localparam logic [3:0] OP_IR = 4'd4;
  localparam logic [3:0] OP_AK = 4'd5;

  // {op, requirement number, data, expected}
  localparam int NV = 45;
  localparam logic [23:0] VEC [NV] = '{
    {OP_WE, 4'd2,  8'h11, 8'h00},  // R2 start setup
    {OP_WO, 4'd2,  8'h20, 8'h00},  // R2 base
    {OP_WO, 4'd2,  8'h04, 8'h00},  // R2 cascade word: slave on line 2
    {OP_WO, 4'd2,  8'h01, 8'h00},  // R2 mode: normal end of service
    {OP_RO, 4'd2,  8'h00, 8'h00},  // R2 mask cleared by setup
    {OP_WO, 4'd4,  8'hF0, 8'h00},  // R4 mask lines 4..7
    {OP_RO, 4'd4,  8'h00, 8'hF0},  // R4
    {OP_IR, 4'd7,  8'h08, 8'h01},  // R7 line 3
    {OP_WE, 4'd5,  8'h0A, 8'h00},  // R5 select request
    {OP_RE, 4'd5,  8'h00, 8'h08},  // R5
    {OP_AK, 4'd3,  8'h00, 8'h23},  // R3
    {OP_WE, 4'd5,  8'h0B, 8'h00},  // R5 select in-service
    {OP_RE, 4'd8,  8'h00, 8'h08},  // R8
    {OP_IR, 4'd7,  8'h09, 8'h01},  // R7 line 0 beats in-service line 3
    {OP_AK, 4'd8,  8'h00, 8'h20},  // R8
    {OP_RE, 4'd5,  8'h00, 8'h09},  // R5 selection persists
    {OP_WE, 4'd6,  8'h60, 8'h00},  // R6 end line 0
    {OP_RE, 4'd6,  8'h00, 8'h08},  // R6 only line 0 cleared
    {OP_WE, 4'd6,  8'h63, 8'h00},  // R6
    {OP_RE, 4'd6,  8'h00, 8'h00},  // R6
    {OP_IR, 4'd10, 8'h00, 8'h00},  // R10
    {OP_IR, 4'd10, 8'h02, 8'h01},  // R10 edge on line 1
    {OP_IR, 4'd10, 8'h00, 8'h00},  // R10 dropped before service
    {OP_AK, 4'd9,  8'h00, 8'h27},  // R9 spurious
    {OP_RE, 4'd9,  8'h00, 8'h00},  // R9 in-service untouched
    {OP_IR, 4'd4,  8'h10, 8'h00},  // R4 masked line 4
    {OP_WE, 4'd4,  8'h0A, 8'h00},  // R4
    {OP_RE, 4'd4,  8'h00, 8'h10},  // R4 masked request still recorded
    {OP_AK, 4'd9,  8'h00, 8'h27},  // R9 masked pending only
    {OP_WE, 4'd9,  8'h0B, 8'h00},  // R9
    {OP_RE, 4'd9,  8'h00, 8'h00},  // R9
    {OP_IR, 4'd7,  8'h00, 8'h00},  // R7
    {OP_IR, 4'd7,  8'h02, 8'h01},  // R7
    {OP_AK, 4'd3,  8'h00, 8'h21},  // R3
    {OP_IR, 4'd7,  8'h00, 8'h00},  // R7
    {OP_IR, 4'd7,  8'h02, 8'h00},  // R7 equal priority blocked
    {OP_IR, 4'd7,  8'h06, 8'h00},  // R7 lower priority blocked
    {OP_IR, 4'd7,  8'h07, 8'h01},  // R7 higher priority passes
    {OP_WE, 4'd6,  8'h20, 8'h00},  // R6 non-specific end
    {OP_RE, 4'd6,  8'h00, 8'h00},  // R6
    {OP_AK, 4'd8,  8'h00, 8'h20},  // R8
    {OP_AK, 4'd7,  8'h00, 8'h27},  // R7 nothing beats line 0 in service
    {OP_WE, 4'd6,  8'h20, 8'h00},  // R6
    {OP_AK, 4'd8,  8'h00, 8'h21},  // R8
    {OP_WE, 4'd6,  8'h20, 8'h00}   // R6
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, rd = 1'b0, a0 = 1'b0;
  logic [7:0] din = '0, ir = '0, level = '0;
  logic       slave = 1'b0, inta = 1'b0;
  logic [2:0] cas_id = '0;
  logic [7:0] dout;
  logic       int_o, cas_en;
  logic [2:0] cas_id_o;
  int         errs = 0, checks = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pic8_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd), .a0_i(a0),
    .din_i(din), .dout_o(dout), .ir_i(ir), .level_i(level), .slave_i(slave),
    .inta_i(inta), .cas_id_i(cas_id), .int_o(int_o), .cas_en_o(cas_en),
    .cas_id_o(cas_id_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic p, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; wr = 1'b1; a0 = p; din = d;
    @(negedge clk); cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic p);
    @(negedge clk); cs = 1'b1; rd = 1'b1; a0 = p;
    @(negedge clk); cs = 1'b0; rd = 1'b0;
  endtask

  task automatic set_ir(input logic [7:0] v);
    @(negedge clk); ir = v;
    @(negedge clk);
  endtask

  task automatic do_ack();
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
  endtask

  task automatic setup(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
    bus_wr(1'b0, 8'h11);
    bus_wr(1'b1, b);
    bus_wr(1'b1, c);
    bus_wr(1'b1, m);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 int_o", {7'd0, int_o}, 8'h00);
    check("R1 dout", dout, 8'h00);
    check("R1 cas_en", {7'd0, cas_en}, 8'h00);
    bus_rd(1'b1);
    check("R1 mask", dout, 8'hFF);
    set_ir(8'h01);
    check("R2 int before setup", {7'd0, int_o}, 8'h00);
    do_ack();
    check("R2 ack before setup", dout, 8'hFF);
    set_ir(8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [3:0] op, rq;
      logic [7:0] d, e;
      string      tag;
      {op, rq, d, e} = VEC[k];
      tag = $sformatf("R%0d vec %0d", rq, k);
      unique case (op)
        OP_WE: bus_wr(1'b0, d);
        OP_WO: bus_wr(1'b1, d);
        OP_RE: begin bus_rd(1'b0); check(tag, dout, e); end
        OP_RO: begin bus_rd(1'b1); check(tag, dout, e); end
        OP_IR: begin set_ir(d); check(tag, {7'd0, int_o}, e); end
        OP_AK: begin do_ack(); check(tag, dout, e); end
        default: ;
      endcase
    end

    // R11: master serves cascaded line 2
    do_ack();
    check("R11 cas_en", {7'd0, cas_en}, 8'h01);
    check("R11 cas_id", {5'd0, cas_id_o}, 8'h02);
    check("R11 dout kept", dout, 8'h21);
    @(negedge clk);
    check("R11 cas_en one cycle", {7'd0, cas_en}, 8'h00);
    bus_rd(1'b0);
    check("R11 in-service", dout, 8'h04);

    // R8 auto end of service, R10 edge capture
    setup(8'h40, 8'h04, 8'h03);
    set_ir(8'h00);
    set_ir(8'h08);
    check("R10 edge request", {7'd0, int_o}, 8'h01);
    do_ack();
    check("R3 vector", dout, 8'h43);
    check("R10 held line no re-request", {7'd0, int_o}, 8'h00);
    bus_wr(1'b0, 8'h0B);
    bus_rd(1'b0);
    check("R8 auto-EOI in-service", dout, 8'h00);

    // R10 level capture
    @(negedge clk); level = 8'h08;
    @(negedge clk);
    @(negedge clk);
    check("R10 level request", {7'd0, int_o}, 8'h01);
    do_ack();
    check("R10 level vector", dout, 8'h43);
    @(negedge clk);
    check("R10 level re-request", {7'd0, int_o}, 8'h01);
    set_ir(8'h00);
    check("R10 level follows line", {7'd0, int_o}, 8'h00);
    level = 8'h00;

    // R12 slave role
    slave = 1'b1;
    setup(8'h70, 8'h02, 8'h01);
    set_ir(8'h20);
    check("R12 slave int", {7'd0, int_o}, 8'h01);
    cas_id = 3'd1;
    do_ack();
    check("R12 other id ignored", dout, 8'h43);
    check("R12 still pending", {7'd0, int_o}, 8'h01);
    cas_id = 3'd2;
    do_ack();
    check("R12 own id vector", dout, 8'h75);
    check("R12 no cascade out", {7'd0, cas_en}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule